// File: doc/BRIEF.md
# Display Blink Timing Controller

This block produces the gate that blanks and restores a multiplexed LED display to make it blink. An 8-bit control word sets its behaviour. The system writes that word through a single-cycle write port. The block holds it and sends the static fields to the neighbouring logic: the clock-source select, the character decode mode and the serial-port enable.

A prescaled tick drives a small timer, one tick for each quarter second of display time. The timer flips the display phase after a programmable number of ticks. Two rates are available, a 1 s period and a 2 s period, each split evenly between on and off. Every write to the control word restarts the timer, so the first phase is the one the word selects. A control bit can make the rising edge of the chip-select/load strobe restart the timer as well. Several devices that share that strobe then blink in lockstep.

One control bit sends a one-cycle reset pulse to the other control registers of the driver. It does not reset the control word itself, the timer or the digit data. The bit clears itself, so it never stays stored.

Top module: `blink_gate_ctrl`

## Requirements
- R1: After reset, ext_clk_o, hex_mode_o, port_en_o and ctrl_rst_o are 0 and disp_en_o is 1.
- R2: A write updates the field outputs on the next clock edge. Bit 0 drives ext_clk_o (1 = external clock). Bit 2 drives hex_mode_o (0 = code-B, 1 = hexadecimal). Bit 3 drives port_en_o (1 = serial port enabled).
- R3: While bit 4 (blink enable) is 0, disp_en_o stays at 1 whatever the ticks, the strobe and the other bits do.
- R4: Every write restarts the blink timer. When bit 4 is set, bit 7 gives the first phase (1 = display on, 0 = display off), and disp_en_o shows that phase right after the write edge.
- R5: With bit 5 at 0, disp_en_o toggles on every HALF_FAST-th tick after the restart (default 2 ticks).
- R6: With bit 5 at 1, disp_en_o toggles on every HALF_SLOW-th tick after the restart (default 4 ticks).
- R7: With bit 6 at 1, a rising edge on load_i clears the tick count and puts the phase back to the start phase given by bit 7. Holding load_i high has no further effect.
- R8: With bit 6 at 0, load_i has no effect on the blink timing.
- R9: Writing bit 1 as 1 drives ctrl_rst_o high for exactly one cycle after the write edge. Bit 1 then reads as 0. The other fields of the same write take effect normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle prescaled time-base pulse |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write data |
| load_i | input | 1 | Chip-select/load strobe, synchronous to clk_i |
| disp_en_o | output | 1 | Display enable gate (1 = lit) |
| ext_clk_o | output | 1 | External clock select |
| hex_mode_o | output | 1 | Decode mode (1 = hexadecimal) |
| port_en_o | output | 1 | Serial port enable |
| ctrl_rst_o | output | 1 | One-cycle reset pulse for other control registers |

## Verification
Every result has one register between stimulus and output. A write, a tick or a load edge presented before a rising edge shows on the outputs right after that edge. The bench drives inputs on the falling edge, holds them for one full cycle and samples on the next falling edge. So each check reads the value the edge in between produced. The phase checks count ticks from the restart and sample after every tick, catching a toggle that comes one tick early or late. The reset pulse is sampled in the cycle after the write and again one cycle later, which confirms that it is exactly one cycle wide.

// File: rtl/blink_pkg.sv
package blink_pkg;
  typedef struct packed {
    logic start_lit;   // bit 7
    logic strobe_sync; // bit 6
    logic slow_rate;   // bit 5
    logic blink_on;    // bit 4
    logic port_en;     // bit 3
    logic hex_sel;     // bit 2
    logic soft_clr;    // bit 1
    logic ext_clk;     // bit 0
  } feat_t;

  localparam int FEAT_W = $bits(feat_t);
endpackage

// File: rtl/blink_feat_reg.sv
module blink_feat_reg
  import blink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [FEAT_W-1:0] wr_data_i,
  output feat_t             feat_o,
  output logic              clr_pulse_o
);
  feat_t wr_feat;
  feat_t feat_q;
  logic  clr_q;

  always_comb begin
    wr_feat          = feat_t'(wr_data_i);
    wr_feat.soft_clr = 1'b0; // self-clearing: never stored
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      feat_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= wr_en_i & wr_data_i[1];
      if (wr_en_i) feat_q <= wr_feat;
    end
  end

  assign feat_o      = feat_q;
  assign clr_pulse_o = clr_q;
endmodule

// File: rtl/blink_strobe_edge.sv
module blink_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/blink_phase_timer.sv
module blink_phase_timer #(
  parameter int HALF_FAST = 2,
  parameter int HALF_SLOW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  input  logic start_on_i,
  input  logic slow_i,
  output logic phase_o
);
  localparam int HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int CNT_W    = $clog2(HALF_MAX) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             phase_q;

  assign last_cnt = slow_i ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q   <= '0;
      phase_q <= start_on_i;
    end else if (tick_i) begin
      // >= so a rate change mid-phase cannot overrun
      if (cnt_q >= last_cnt) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/blink_gate_ctrl.sv
module blink_gate_ctrl
  import blink_pkg::*;
#(
  parameter int HALF_FAST = 2,
  parameter int HALF_SLOW = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       load_i,
  output logic       disp_en_o,
  output logic       ext_clk_o,
  output logic       hex_mode_o,
  output logic       port_en_o,
  output logic       ctrl_rst_o
);
  feat_t feat;
  logic  load_rise;
  logic  restart;
  logic  start_on;
  logic  phase;

  blink_feat_reg u_feat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .feat_o     (feat),
    .clr_pulse_o(ctrl_rst_o)
  );

  blink_strobe_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(load_i),
    .rise_o  (load_rise)
  );

  // a write restarts with its own start bit; idle blink parks at start phase
  assign restart  = wr_en_i | ~feat.blink_on | (feat.strobe_sync & load_rise);
  assign start_on = wr_en_i ? wr_data_i[7] : feat.start_lit;

  blink_phase_timer #(
    .HALF_FAST(HALF_FAST),
    .HALF_SLOW(HALF_SLOW)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .restart_i (restart),
    .start_on_i(start_on),
    .slow_i    (feat.slow_rate),
    .phase_o   (phase)
  );

  assign disp_en_o  = ~feat.blink_on | phase;
  assign ext_clk_o  = feat.ext_clk;
  assign hex_mode_o = feat.hex_sel;
  assign port_en_o  = feat.port_en;
endmodule

// File: rtl/blink_gate_ctrl_chk.sv
module blink_gate_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       load_i,
  input logic       blink_on_i,
  input logic       disp_en_o,
  input logic       ctrl_rst_o
);
  a_r3_steady_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blink_on_i |-> disp_en_o);

  a_r4_start_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (disp_en_o == (!$past(wr_data_i[4]) || $past(wr_data_i[7]))));

  a_r9_pulse_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_o |-> $past(wr_en_i && wr_data_i[1]));

  a_r9_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[1]) |=> ctrl_rst_o);

  a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i && !load_i) |=> $stable(disp_en_o));
endmodule

bind blink_gate_ctrl blink_gate_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .load_i    (load_i),
  .blink_on_i(feat.blink_on),
  .disp_en_o (disp_en_o),
  .ctrl_rst_o(ctrl_rst_o)
);

// File: tb/blink_gate_ctrl_tb.sv
module blink_gate_ctrl_tb;
  localparam int TCLK = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       load_i = 1'b0;
  logic       disp_en_o, ext_clk_o, hex_mode_o, port_en_o, ctrl_rst_o;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk_i = ~clk_i;

  blink_gate_ctrl u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .load_i    (load_i),
    .disp_en_o (disp_en_o),
    .ext_clk_o (ext_clk_o),
    .hex_mode_o(hex_mode_o),
    .port_en_o (port_en_o),
    .ctrl_rst_o(ctrl_rst_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic tick();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ext_clk", ext_clk_o, 1'b0);
    chk("R1 hex_mode", hex_mode_o, 1'b0);
    chk("R1 port_en", port_en_o, 1'b0);
    chk("R1 ctrl_rst", ctrl_rst_o, 1'b0);
    chk("R1 disp_en", disp_en_o, 1'b1);
  endtask

  task automatic t_fields();
    wr(8'h01);
    chk("R2 ext_clk", ext_clk_o, 1'b1);
    chk("R2 hex_mode", hex_mode_o, 1'b0);
    wr(8'h0C);
    chk("R2 ext_clk off", ext_clk_o, 1'b0);
    chk("R2 hex_mode", hex_mode_o, 1'b1);
    chk("R2 port_en", port_en_o, 1'b1);
  endtask

  task automatic t_disabled();
    wr(8'hE0); // slow, sync, start bit, blink off
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R3 held on", disp_en_o, 1'b1);
    end
    @(negedge clk_i); load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
    chk("R3 held on after load", disp_en_o, 1'b1);
  endtask

  task automatic t_start_off_fast();
    wr(8'h10);
    chk("R4 start off", disp_en_o, 1'b0);
    tick(); chk("R5 tick1", disp_en_o, 1'b0);
    tick(); chk("R5 tick2", disp_en_o, 1'b1);
    tick(); chk("R5 tick3", disp_en_o, 1'b1);
    tick(); chk("R5 tick4", disp_en_o, 1'b0);
  endtask

  task automatic t_start_on_slow();
    wr(8'hB0);
    chk("R4 start on", disp_en_o, 1'b1);
    for (int i = 1; i <= 8; i++) begin
      tick();
      chk("R6 slow phase", disp_en_o, (i >= 4 && i < 8) ? 1'b0 : 1'b1);
    end
    wr(8'h30);
    chk("R4 restart off", disp_en_o, 1'b0);
  endtask

  task automatic t_sync();
    wr(8'hD0); // start on, sync, fast, blink
    tick(); chk("R7 pre", disp_en_o, 1'b1);
    @(negedge clk_i); load_i = 1'b1;
    @(negedge clk_i);
    chk("R7 after edge", disp_en_o, 1'b1);
    tick(); chk("R7 count cleared", disp_en_o, 1'b1);
    tick(); chk("R7 toggle", disp_en_o, 1'b0);
    tick(); chk("R7 level ignored", disp_en_o, 1'b0);
    tick(); chk("R7 level ignored 2", disp_en_o, 1'b1);
    @(negedge clk_i); load_i = 1'b0;
    tick(); tick(); // phase now off, count 0
    chk("R7 pre edge off", disp_en_o, 1'b0);
    @(negedge clk_i); load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
    chk("R7 back to start", disp_en_o, 1'b1);
  endtask

  task automatic t_nosync();
    wr(8'h90);
    tick();
    @(negedge clk_i); load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
    chk("R8 load ignored", disp_en_o, 1'b1);
    tick(); chk("R8 toggle unaffected", disp_en_o, 1'b0);
  endtask

  task automatic t_soft_clear();
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = 8'h0F;
    @(negedge clk_i); wr_en_i = 1'b0; wr_data_i = '0;
    chk("R9 pulse high", ctrl_rst_o, 1'b1);
    chk("R9 ext_clk kept", ext_clk_o, 1'b1);
    chk("R9 hex kept", hex_mode_o, 1'b1);
    chk("R9 port kept", port_en_o, 1'b1);
    @(negedge clk_i);
    chk("R9 pulse low", ctrl_rst_o, 1'b0);
    @(negedge clk_i);
    chk("R9 stays low", ctrl_rst_o, 1'b0);
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fields();
    t_disabled();
    t_start_off_fast();
    t_start_on_slow();
    t_sync();
    t_nosync();
    t_soft_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule